// File: doc/BRIEF.md
# Serial Link Frame Encoder

This block turns one parallel word per word-clock cycle into one line frame for a synchronous serial link. The word is 16 or 20 bits wide, chosen at run time by a mode input. Each frame carries a 4-bit coded control field and then the data field, so a frame is 20 or 24 bits. The control field tells the far end what the frame is: user data, a control word, an idle fill frame or one of two training frames. It also shows whether the frame was sent inverted.

The two strobes are active low. A control word takes precedence over a data word. When neither strobe is asserted, fill frames keep the receiver in frame and bit lock. From reset until the start input is seen, only training frames are sent, and the strobes have no effect. A running disparity sum keeps the line DC balanced. A frame whose disparity has the same sign as the sum is sent fully inverted. The flag input can ride along as an extra user bit. When the flag is not in use, its two code positions carry a fixed pattern, and a receiver can treat any other value there as an error.

The serializer, the clock multiplier and the line driver lie outside this block. The output is the registered parallel frame.

Top module: `link_frame_encoder`

## Requirements
- R1: The control field occupies frame bits [3:0] and the data field starts at bit 4. The field is 20 bits when `wide_i`=1 and 16 bits when `wide_i`=0. Frame bits above the active width (bits 23:20 in narrow mode) are always 0.
- R2: A data frame is sent in true polarity with control field 4'b10xy. When `flag_en_i`=1, xy = {flag, ~flag}. When `flag_en_i`=0, xy = 2'b01. The data field is the low field-width bits of `data_i`.
- R3: When running and `ctl_n_i`=0, a control frame is sent whatever the value of `dat_n_i`. Its true-polarity control field is 4'b1100. The field's low 14 bits (narrow) or 18 bits (wide) come from `data_i`, and the field's top two bits are 2'b01 (the MSB is 0).
- R4: When running and both strobes are high, a fill frame is sent. It has control field 4'b1110 and a field whose even-indexed bits are 1 and odd-indexed bits are 0.
- R5: Before start, every frame is a training frame with control field 4'b1110. With `train_hi_i`=0 the low half of the field is ones and the upper half is zeros. With `train_hi_i`=1 the upper half is ones and the low half is zeros. The strobes, flag and data are ignored.
- R6: A cycle that samples `start_i`=1 already produces a normal frame. From then on the encoder stays running until reset, even after `start_i` falls.
- R7: Let the frame disparity be the number of ones minus the number of zeros over the active frame width. When the disparity and the running sum are both nonzero and share a sign, the whole active frame is sent bitwise inverted. An inverted data frame therefore shows 2'b01 in bits [3:2].
- R8: The running sum is 0 after reset. Each cycle it adds the disparity of the frame actually sent, so its magnitude never exceeds the frame width.
- R9: A frame built from the inputs sampled at one rising clock edge appears right after that edge and holds until the next edge.
- R10: While `rst_n` is low, `frame_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 = 20-bit word, 0 = 16-bit word |
| start_i | input | 1 | Leave training and begin normal traffic (sticky) |
| train_hi_i | input | 1 | Selects which of the two training frames is sent |
| ctl_n_i | input | 1 | Control word offered (active low) |
| dat_n_i | input | 1 | Data word offered (active low) |
| flag_i | input | 1 | Extra user bit sent with data frames |
| flag_en_i | input | 1 | 1 = carry the flag, 0 = fixed error-check pattern |
| data_i | input | DW_MAX (20) | Parallel word |
| frame_o | output | DW_MAX+4 (24) | Registered line frame |

## Verification
The bench builds the encoder with its default widths: a 20-bit wide word and a 16-bit narrow word. Both frame sizes, and the padding above the narrow frame, can therefore be reached by toggling the mode input at run time. With these widths, all-ones words give a disparity of plus 20, large enough to push the running sum well away from zero. This exposes the same-sign inversion rule and the zero-disparity case in both directions. The two truncation points for control words (bit 14 and bit 18) also fall inside the field the bench drives.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

   typedef enum logic [2:0] {
      FK_TRAIN_LO = 3'd0,
      FK_TRAIN_HI = 3'd1,
      FK_FILL     = 3'd2,
      FK_CTRL     = 3'd3,
      FK_DATA     = 3'd4
   } frame_kind_e;

   localparam int unsigned CF_W = 4;

   // true-polarity control field codes
   localparam logic [1:0] CF_DATA_MARK = 2'b10;
   localparam logic [1:0] CF_FLAG_IDLE = 2'b01;
   localparam logic [3:0] CF_CTRL      = 4'b1100;
   localparam logic [3:0] CF_FILL      = 4'b1110;

   // fixed top bits of a control-word field
   localparam logic [1:0] CTRL_PAD     = 2'b01;

   // signed width that holds +/- fw with margin
   function automatic int sum_width(input int fw);
      return $clog2(fw + 1) + 2;
   endfunction

endpackage

// File: rtl/lfe_kind_select.sv
module lfe_kind_select
   import lfe_pkg::*;
(
   input  logic        run_i,
   input  logic        train_hi_i,
   input  logic        ctl_n_i,
   input  logic        dat_n_i,
   output frame_kind_e kind_o
);

   always_comb begin
      if (!run_i) begin
         kind_o = train_hi_i ? FK_TRAIN_HI : FK_TRAIN_LO;
      end else if (!ctl_n_i) begin
         kind_o = FK_CTRL;
      end else if (!dat_n_i) begin
         kind_o = FK_DATA;
      end else begin
         kind_o = FK_FILL;
      end
   end

endmodule

// File: rtl/lfe_frame_build.sv
module lfe_frame_build
   import lfe_pkg::*;
#(
   parameter int DW_MAX = 20,
   parameter int DW_MIN = 16,
   localparam int FW    = DW_MAX + CF_W
)(
   input  frame_kind_e       kind_i,
   input  logic              wide_i,
   input  logic [DW_MAX-1:0] data_i,
   input  logic              flag_i,
   input  logic              flag_en_i,
   output logic [FW-1:0]     frame_o
);

   // one lane per word width; the mode input picks the lane
   for (genvar gi = 0; gi < 2; gi++) begin : g_lane
      localparam int W = (gi == 1) ? DW_MAX : DW_MIN;
      logic [W-1:0]    field;
      logic [CF_W-1:0] cf;
      logic [FW-1:0]   cand;

      always_comb begin
         field = '0;
         cf    = CF_FILL;
         case (kind_i)
            FK_DATA: begin
               field = data_i[W-1:0];
               cf    = {CF_DATA_MARK, (flag_en_i ? {flag_i, ~flag_i} : CF_FLAG_IDLE)};
            end
            FK_CTRL: begin
               field[W-3:0]   = data_i[W-3:0];
               field[W-1:W-2] = CTRL_PAD;
               cf             = CF_CTRL;
            end
            FK_FILL: begin
               for (int b = 0; b < W; b++) field[b] = ((b % 2) == 0);
            end
            FK_TRAIN_LO: field[W/2-1:0] = '1;
            FK_TRAIN_HI: field[W-1:W/2] = '1;
            default: ;
         endcase
         cand = '0;
         cand[W+CF_W-1:0] = {field, cf};
      end
   end

   assign frame_o = wide_i ? g_lane[1].cand : g_lane[0].cand;

endmodule

// File: rtl/lfe_disparity.sv
module lfe_disparity
   import lfe_pkg::*;
#(
   parameter int FW  = 24,
   parameter int NFW = 20,
   localparam int SW = sum_width(FW)
)(
   input  logic [FW-1:0]        frame_i,
   input  logic                 wide_i,
   output logic signed [SW-1:0] disp_o
);

   logic [SW-1:0] ones;
   logic [SW-1:0] act_w;

   always_comb begin
      ones = '0;
      for (int i = 0; i < FW; i++) ones = ones + SW'(frame_i[i]);
      act_w  = wide_i ? SW'(FW) : SW'(NFW);
      disp_o = $signed((ones << 1) - act_w);
   end

endmodule

// File: rtl/lfe_balance.sv
module lfe_balance
   import lfe_pkg::*;
#(
   parameter int FW  = 24,
   localparam int SW = sum_width(FW)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [SW-1:0] disp_i,
   output logic                 inv_o,
   output logic signed [SW-1:0] sum_o
);

   logic signed [SW-1:0] sum_q;
   logic signed [SW-1:0] sum_d;

   always_comb begin
      inv_o = ((disp_i > 0) && (sum_q > 0)) || ((disp_i < 0) && (sum_q < 0));
      sum_d = inv_o ? (sum_q - disp_i) : (sum_q + disp_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_d;
   end

   assign sum_o = sum_q;

endmodule

// File: rtl/link_frame_encoder.sv
module link_frame_encoder
   import lfe_pkg::*;
#(
   parameter int DW_MAX = 20,
   parameter int DW_MIN = 16,
   localparam int FW    = DW_MAX + CF_W,
   localparam int NFW   = DW_MIN + CF_W,
   localparam int SW    = sum_width(FW)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_i,
   input  logic              start_i,
   input  logic              train_hi_i,
   input  logic              ctl_n_i,
   input  logic              dat_n_i,
   input  logic              flag_i,
   input  logic              flag_en_i,
   input  logic [DW_MAX-1:0] data_i,
   output logic [FW-1:0]     frame_o
);

   if (DW_MAX <= DW_MIN) begin : g_bad_order
      $error("DW_MAX must exceed DW_MIN");
   end
   if ((DW_MIN < 4) || ((DW_MIN % 2) != 0) || ((DW_MAX % 2) != 0)) begin : g_bad_width
      $error("word widths must be even and at least 4");
   end

   localparam logic [FW-1:0] NARROW_MASK = {{(FW-NFW){1'b0}}, {NFW{1'b1}}};

   logic                 started_q;
   logic                 run;
   frame_kind_e          kind;
   logic [FW-1:0]        frame_true;
   logic [FW-1:0]        act_mask;
   logic [FW-1:0]        frame_d;
   logic signed [SW-1:0] disp;
   logic signed [SW-1:0] run_sum;
   logic                 inv;

   assign run = started_q | start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       started_q <= 1'b0;
      else if (start_i) started_q <= 1'b1;
   end

   lfe_kind_select u_kind (
      .run_i      (run),
      .train_hi_i (train_hi_i),
      .ctl_n_i    (ctl_n_i),
      .dat_n_i    (dat_n_i),
      .kind_o     (kind)
   );

   lfe_frame_build #(.DW_MAX(DW_MAX), .DW_MIN(DW_MIN)) u_build (
      .kind_i    (kind),
      .wide_i    (wide_i),
      .data_i    (data_i),
      .flag_i    (flag_i),
      .flag_en_i (flag_en_i),
      .frame_o   (frame_true)
   );

   lfe_disparity #(.FW(FW), .NFW(NFW)) u_disp (
      .frame_i (frame_true),
      .wide_i  (wide_i),
      .disp_o  (disp)
   );

   lfe_balance #(.FW(FW)) u_bal (
      .clk    (clk),
      .rst_n  (rst_n),
      .disp_i (disp),
      .inv_o  (inv),
      .sum_o  (run_sum)
   );

   always_comb begin
      act_mask = wide_i ? {FW{1'b1}} : NARROW_MASK;
      frame_d  = inv ? (~frame_true & act_mask) : frame_true;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_o <= '0;
      else        frame_o <= frame_d;
   end

endmodule

// File: rtl/lfe_checker.sv
module lfe_checker
   import lfe_pkg::*;
#(
   parameter int DW_MAX = 20,
   parameter int DW_MIN = 16,
   localparam int FW    = DW_MAX + CF_W,
   localparam int NFW   = DW_MIN + CF_W,
   localparam int SW    = sum_width(FW)
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wide_i,
   input logic                 start_i,
   input logic                 ctl_n_i,
   input logic                 dat_n_i,
   input logic                 started_q,
   input logic signed [SW-1:0] run_sum,
   input logic [FW-1:0]        frame_o
);

   logic run_c;
   assign run_c = started_q | start_i;

   p_narrow_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_i |=> (frame_o[FW-1:NFW] == '0));

   p_data_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && ctl_n_i && !dat_n_i) |=> (frame_o[3:2] == 2'b10 || frame_o[3:2] == 2'b01));

   p_ctrl_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && !ctl_n_i) |=> (frame_o[3:0] == 4'b1100 || frame_o[3:0] == 4'b0011));

   p_fill_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && ctl_n_i && dat_n_i) |=> (frame_o[3:0] == 4'b1110 || frame_o[3:0] == 4'b0001));

   p_train_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!started_q && !start_i) |=> (frame_o[3:0] == 4'b1110 || frame_o[3:0] == 4'b0001));

   p_start_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      started_q |=> started_q);

   p_sum_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(run_sum) <= FW) && (int'(run_sum) >= -FW));

endmodule

bind link_frame_encoder lfe_checker #(.DW_MAX(DW_MAX), .DW_MIN(DW_MIN)) u_lfe_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wide_i    (wide_i),
   .start_i   (start_i),
   .ctl_n_i   (ctl_n_i),
   .dat_n_i   (dat_n_i),
   .started_q (started_q),
   .run_sum   (run_sum),
   .frame_o   (frame_o)
);

// File: tb/link_frame_encoder_bench.sv
module link_frame_encoder_bench;

   localparam int DWM = 20;
   localparam int FWM = 24;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wide_i = 1'b1;
   logic           start_i = 1'b0;
   logic           train_hi_i = 1'b0;
   logic           ctl_n_i = 1'b1;
   logic           dat_n_i = 1'b1;
   logic           flag_i = 1'b0;
   logic           flag_en_i = 1'b0;
   logic [DWM-1:0] data_i = '0;
   logic [FWM-1:0] frame_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   int             m_sum = 0;
   bit             m_started = 0;
   logic [FWM-1:0] m_prev = '0;

   always #10 clk = ~clk;

   link_frame_encoder u_link_frame_encoder (
      .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .start_i(start_i),
      .train_hi_i(train_hi_i), .ctl_n_i(ctl_n_i), .dat_n_i(dat_n_i),
      .flag_i(flag_i), .flag_en_i(flag_en_i), .data_i(data_i), .frame_o(frame_o)
   );

   task automatic check(input logic [FWM-1:0] got, input logic [FWM-1:0] exp, input string req);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // kinds: 0 train lo, 1 train hi, 2 fill, 3 ctrl, 4 data
   function automatic logic [FWM-1:0] m_true(input int k, input logic w, input logic fl,
                                             input logic fe, input logic [DWM-1:0] d);
      int W = w ? 20 : 16;
      logic [DWM-1:0] f = '0;
      logic [3:0] cf = 4'b1110;
      case (k)
         0: for (int b = 0; b < W/2; b++) f[b] = 1'b1;
         1: for (int b = W/2; b < W; b++) f[b] = 1'b1;
         2: for (int b = 0; b < W; b += 2) f[b] = 1'b1;
         3: begin
            for (int b = 0; b < W-2; b++) f[b] = d[b];
            f[W-2] = 1'b1;
            cf = 4'b1100;
         end
         default: begin
            for (int b = 0; b < W; b++) f[b] = d[b];
            cf = fe ? {2'b10, fl, ~fl} : 4'b1001;
         end
      endcase
      return ({4'b0, f} << 4) | FWM'(cf);
   endfunction

   task automatic reset_dut();
      @(negedge clk);
      rst_n = 1'b0; start_i = 1'b0;
      @(negedge clk);
      check(frame_o, '0, "R10");
      rst_n = 1'b1;
      m_sum = 0; m_started = 0; m_prev = '0;
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic apply(input logic st, input logic th, input logic cn, input logic dn,
                        input logic fl, input logic fe, input logic w,
                        input logic [DWM-1:0] d, input string req);
      int k, ones, dsp, aw;
      bit run, inv;
      logic [FWM-1:0] t, e, mask;
      start_i = st; train_hi_i = th; ctl_n_i = cn; dat_n_i = dn;
      flag_i = fl; flag_en_i = fe; wide_i = w; data_i = d;
      run = m_started || st;
      k = !run ? (th ? 1 : 0) : (!cn ? 3 : (!dn ? 4 : 2));
      t = m_true(k, w, fl, fe, d);
      aw = w ? 24 : 20;
      ones = 0;
      for (int b = 0; b < FWM; b++) ones += int'(t[b]);
      dsp = 2 * ones - aw;
      inv = (dsp > 0 && m_sum > 0) || (dsp < 0 && m_sum < 0);
      mask = w ? '1 : 24'h0F_FFFF;
      e = inv ? (~t & mask) : t;
      m_sum += inv ? -dsp : dsp;
      m_started = run;
      #5 check(frame_o, m_prev, "R9 hold");
      @(negedge clk);
      check(frame_o, e, req);
      m_prev = e;
   endtask

   task automatic t_training();
      apply(0, 0, 0, 0, 1, 1, 1, 20'hFFFFF, "R5 train lo");
      apply(0, 1, 0, 0, 1, 1, 1, 20'hFFFFF, "R5 train hi");
      apply(0, 0, 1, 0, 0, 0, 0, 20'h12345, "R5 train lo narrow");
      apply(0, 1, 1, 1, 0, 0, 0, 20'h00000, "R5 train hi narrow");
      apply(0, 1, 0, 1, 0, 0, 1, 20'h0F0F0, "R5 train hi wide");
   endtask

   task automatic t_start();
      apply(1, 0, 1, 0, 0, 0, 1, 20'hABCDE, "R6 start edge data");
      apply(0, 0, 1, 0, 0, 0, 1, 20'h13579, "R6 after start drop");
      apply(0, 1, 1, 1, 0, 0, 1, 20'h0, "R6 fill after start");
   endtask

   task automatic t_data();
      apply(0, 0, 1, 0, 1, 1, 1, 20'h00000, "R2 flag=1");
      apply(0, 0, 1, 0, 0, 1, 1, 20'h0000F, "R2 flag=0");
      apply(0, 0, 1, 0, 1, 0, 1, 20'hFFFFF, "R2 flag off");
      apply(0, 0, 1, 0, 1, 1, 1, 20'h55AA5, "R7 balanced word");
      apply(0, 0, 1, 0, 0, 1, 1, 20'hFFFF0, "R7 data");
   endtask

   task automatic t_ctrl();
      apply(0, 0, 0, 0, 1, 1, 1, 20'hFFFFF, "R3 ctrl wins wide");
      apply(0, 0, 0, 1, 0, 0, 0, 20'hFFFFF, "R3 ctrl narrow");
      apply(0, 0, 0, 1, 0, 0, 1, 20'h00000, "R3 ctrl zero");
      apply(0, 0, 0, 0, 0, 0, 0, 20'h2AAAA, "R3 ctrl narrow pattern");
   endtask

   task automatic t_fill();
      apply(0, 0, 1, 1, 1, 1, 1, 20'hFFFFF, "R4 fill wide");
      apply(0, 0, 1, 1, 0, 0, 0, 20'hFFFFF, "R4 fill narrow");
      apply(0, 1, 1, 1, 0, 0, 1, 20'h0, "R4 fill wide again");
   endtask

   task automatic t_narrow();
      apply(0, 0, 1, 0, 1, 1, 0, 20'hFFFFF, "R1 narrow data pad");
      apply(0, 0, 1, 0, 0, 1, 0, 20'hF0000, "R1 narrow ignores top bits");
      apply(0, 0, 1, 0, 0, 0, 0, 20'h0FFFF, "R1 narrow ones");
   endtask

   task automatic t_balance();
      reset_dut();
      // fixed values: sum 0 -> true, sum +20 -> inverted
      apply(1, 0, 1, 0, 0, 0, 1, 20'hFFFFF, "R8 first frame");
      check(frame_o, 24'hFFFFF9, "R8 sum starts at zero");
      apply(0, 0, 1, 0, 0, 0, 1, 20'hFFFFF, "R7 second frame");
      check(frame_o, 24'h000006, "R7 inverted frame");
      for (int i = 0; i < 12; i++)
         apply(0, 0, 1, 0, i[0], 1, i[1], 20'hFFFFF ^ (20'h00F0F << i), "R7 R8 sweep");
      for (int i = 0; i < 6; i++)
         apply(0, 0, 1, 0, 0, 0, 1, 20'h00000, "R7 zeros run");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog: got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      reset_dut();
      t_training();
      t_start();
      t_data();
      t_ctrl();
      t_fill();
      t_narrow();
      t_balance();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule